// File: doc/BRIEF.md
# Two-Way Lockable Data Cache Controller

This block is the controller for an 8 KB data cache. The cache has two ways of 128 sets, and each line is 32 bytes, held as eight 32-bit words. A core issues one access at a time. Each access carries three things: the low 12 bits of its virtual address, which select the set and the word; the 20-bit physical page tag from translation, which is compared against the stored tags; and a two-bit policy code. The policy code sets the write behaviour for that one access: write-back, write-through with allocation, write-through without allocation, or uncached.

Misses and write-through traffic leave on a simple memory port with four operations: line read, line write, word read and word write. The port uses a valid/ready handshake. A dirty victim is written back as a whole line before its replacement is fetched. When the `lock_a` input is high, way 0 is frozen, so its lines stay resident and every refill goes to way 1. When `lock_a` is low, a per-set LRU bit chooses the victim.

Each data byte is stored with an even-parity bit, and each tag is stored with one parity bit. The data parity bits for a refill come from the memory port with the line. A load whose word shows a parity mismatch is flagged on `parity_err` and handled as a miss: the damaged line is dropped and fetched again.

Top module: `dcache_lockable`

## Requirements
- R1: After reset, `req_ready` is high and `mem_valid` and `resp_valid` are low. Every line is invalid, so the first cached access misses. `mem_valid` is never high while `req_ready` is high.
- R2: The set index is `req_vaddr[11:5]` and the word within the line is `req_vaddr[4:2]`. A line operation uses address {tag, index, 5'b0}, and a word operation uses address {tag, index, word, 2'b00}. `mem_op` codes are: 0 line read, 1 line write, 2 word read, 3 word write. Word k of a line occupies bits 32k+31..32k. While `mem_valid` is high and `mem_ready` is low, the operation and address stay stable.
- R3: A cached load that hits returns the stored word one cycle after the lookup and produces no memory traffic. Each request ends with exactly one `resp_valid` pulse, in a cycle where `req_ready` is high.
- R4: While `lock_a` is high, a refill always goes to way 1. Lines already held in way 0 keep hitting.
- R5: While `lock_a` is low, the victim is the least recently used way of the set. Every hit and every refill makes the touched way the most recently used.
- R6: Policy code 0 (write-back). A store hit merges the enabled bytes, marks the line dirty and produces no memory traffic. A store miss first refills the line and then merges the store into it.
- R7: A refill whose victim is valid and dirty is preceded by a line write of the victim's data to the victim's own address. The line read follows in the very next cycle after that write completes.
- R8: Policy code 1 (write-through with allocation). A store updates the cache and also issues a word write with the store data and byte enables. A miss refills the line first. The dirty bit is left as it was, so a clean line evicted later is not written back.
- R9: Policy code 2 (write-through without allocation). A store miss issues only a word write and allocates no line. A store hit behaves as under policy code 1.
- R10: Policy code 3 (uncached). A load issues a word read and returns memory's data, even if the cache holds different data for that address. A store issues a word write. The cache contents and LRU state are left unchanged either way.
- R11: `mem_rpar` bit 4k+b is stored as the parity of byte b of word k of the refilled line, where even parity is the XOR of the byte's bits. When a cached load reads a word whose stored parity mismatches, `parity_err` pulses for one cycle, the line is invalidated without a writeback, and the line is fetched again. The load then returns the new data. A mismatch in a word that was not read raises nothing.
- R12: A store writes a fresh parity bit for each byte it writes. A byte with bad parity that is fully overwritten no longer raises an error. A bad byte that the store did not enable still does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_a | input | 1 | Freeze way 0 against replacement |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller idle, request accepted |
| req_we | input | 1 | 1 store, 0 load |
| req_mode | input | 2 | Policy: 0 write-back, 1 write-through allocate, 2 write-through no allocate, 3 uncached |
| req_vaddr | input | 12 | Virtual address low bits (index and word) |
| req_ptag | input | 20 | Physical tag, address bits 31..12 |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| resp_valid | output | 1 | Request complete, one cycle |
| resp_rdata | output | 32 | Load data |
| parity_err | output | 1 | Parity mismatch seen during lookup |
| mem_valid | output | 1 | Memory operation pending |
| mem_op | output | 2 | Operation code |
| mem_addr | output | 32 | Byte address |
| mem_wline | output | 256 | Line data for line writes |
| mem_wdata | output | 32 | Word data for word writes |
| mem_wbe | output | 4 | Byte enables for word writes |
| mem_ready | input | 1 | Operation complete, read data valid |
| mem_rline | input | 256 | Read line; a word read uses bits 31..0 |
| mem_rpar | input | 32 | Byte parity for the read line |

## Verification
The hardest situation to reach from the ports is a parity mismatch. Parity is generated from the data, so a corrupt byte cannot appear on its own. The stimulus therefore flips chosen bits of `mem_rpar` on a single refill. Later loads then read either the damaged word or an intact word of the same line, and one store overwrites the damaged byte while another leaves it in place. Locked-way and dirty-eviction behaviour come from packing several tags into one set in a deliberate order, so the LRU state at each miss is known in advance.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {POL_WB = 2'd0, POL_WTA = 2'd1, POL_WTNA = 2'd2, POL_UC = 2'd3} pol_e;
  typedef enum logic [1:0] {MOP_RDLINE = 2'd0, MOP_WRLINE = 2'd1, MOP_RDWORD = 2'd2, MOP_WRWORD = 2'd3} mop_e;
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WBK, S_FILL, S_MEMW} st_e;

  // even parity of each byte of a word
  function automatic logic [3:0] byte_par(input logic [31:0] w);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ^w[8*b +: 8];
    return p;
  endfunction
endpackage

// File: rtl/dcache_tags.sv
module dcache_tags #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 20,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic [1:0]       hit_vec,
  output logic [1:0]       tperr_vec,
  output logic [1:0]       valid_vec,
  output logic [1:0]       dirty_vec,
  output logic             lru_way,
  input  logic             sel_way,
  output logic [TAG_W-1:0] sel_tag,
  input  logic             alloc_en,
  input  logic             alloc_way,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             dirty_en,
  input  logic             dirty_way,
  input  logic [1:0]       inval_vec
);
  logic [TAG_W-1:0] tag_q  [2][SETS];
  logic             tpar_q [2][SETS];
  logic             vld_q  [2][SETS];
  logic             drt_q  [2][SETS];
  logic             lru_q  [SETS];

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tag_q[alloc_way][idx]  <= alloc_tag;
      tpar_q[alloc_way][idx] <= ^alloc_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        lru_q[s] <= 1'b0;
        for (int w = 0; w < 2; w++) begin
          vld_q[w][s] <= 1'b0;
          drt_q[w][s] <= 1'b0;
        end
      end
    end else begin
      for (int w = 0; w < 2; w++) begin
        if (inval_vec[w]) vld_q[w][idx] <= 1'b0;
        if (alloc_en && alloc_way == w[0]) begin
          vld_q[w][idx] <= 1'b1;
          drt_q[w][idx] <= 1'b0;
        end
        if (dirty_en && dirty_way == w[0]) drt_q[w][idx] <= 1'b1;
      end
      if (touch_en) lru_q[idx] <= ~touch_way;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign valid_vec[w] = vld_q[w][idx];
    assign dirty_vec[w] = drt_q[w][idx];
    assign tperr_vec[w] = vld_q[w][idx] && (tpar_q[w][idx] != ^tag_q[w][idx]);
    assign hit_vec[w]   = vld_q[w][idx] && (tag_q[w][idx] == tag) && !tperr_vec[w];
  end

  assign lru_way = lru_q[idx];
  assign sel_tag = tag_q[sel_way][idx];
endmodule

// File: rtl/dcache_data.sv
module dcache_data #(
  parameter int IDX_W  = 7,
  parameter int WSEL_W = 3,
  localparam int WORDS  = 1 << WSEL_W,
  localparam int LINE_W = WORDS * 32,
  localparam int DEPTH  = (1 << IDX_W) * WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WSEL_W-1:0] wsel,
  output logic [1:0][31:0]  rd_word,
  output logic [1:0][3:0]   rd_par,
  input  logic              ev_way,
  output logic [LINE_W-1:0] ev_line,
  input  logic              st_en,
  input  logic              st_way,
  input  logic [31:0]       st_data,
  input  logic [3:0]        st_be,
  input  logic              fill_en,
  input  logic              fill_way,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [WORDS*4-1:0] fill_par
);
  logic [31:0] dat_q [2][DEPTH];
  logic [3:0]  par_q [2][DEPTH];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int k = 0; k < WORDS; k++) begin
        dat_q[fill_way][{idx, WSEL_W'(k)}] <= fill_line[32*k +: 32];
        par_q[fill_way][{idx, WSEL_W'(k)}] <= fill_par[4*k +: 4];
      end
    end else if (st_en) begin
      for (int b = 0; b < 4; b++) begin
        if (st_be[b]) begin
          dat_q[st_way][{idx, wsel}][8*b +: 8] <= st_data[8*b +: 8];
          par_q[st_way][{idx, wsel}][b]        <= ^st_data[8*b +: 8];
        end
      end
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign rd_word[w] = dat_q[w][{idx, wsel}];
    assign rd_par[w]  = par_q[w][{idx, wsel}];
  end

  always_comb begin
    for (int k = 0; k < WORDS; k++) ev_line[32*k +: 32] = dat_q[ev_way][{idx, WSEL_W'(k)}];
  end
endmodule

// File: rtl/dcache_lockable.sv
module dcache_lockable
  import dcache_pkg::*;
#(
  parameter int VA_W  = 12,
  parameter int PA_W  = 32,
  parameter int OFF_W = 5,
  localparam int IDX_W  = VA_W - OFF_W,
  localparam int TAG_W  = PA_W - VA_W,
  localparam int WSEL_W = OFF_W - 2,
  localparam int WORDS  = 1 << WSEL_W,
  localparam int LINE_W = WORDS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_a,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_mode,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [TAG_W-1:0]  req_ptag,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              parity_err,
  output logic              mem_valid,
  output logic [1:0]        mem_op,
  output logic [PA_W-1:0]   mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wbe,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rline,
  input  logic [WORDS*4-1:0] mem_rpar
);
  st_e               st;
  logic              r_we, r_vic;
  pol_e              r_mode;
  logic [IDX_W-1:0]  r_idx;
  logic [WSEL_W-1:0] r_wsel;
  logic [TAG_W-1:0]  r_tag, sel_tag;
  logic [31:0]       r_wdata;
  logic [3:0]        r_be;

  logic [1:0]       hit_vec, tperr_vec, valid_vec, dirty_vec, inval_vec;
  logic             lru_way, hit_way, any_hit, good_hit, dperr, vic, wb_need;
  logic [1:0][31:0] rd_word;
  logic [1:0][3:0]  rd_par;

  // named internal events, also observed by the checker
  logic look_act, wtna_miss, alloc_dec, fill_done, fill_way, cur_uc, st_en;

  assign hit_way   = hit_vec[1];
  assign any_hit   = |hit_vec;
  assign dperr     = !r_we && any_hit && (byte_par(rd_word[hit_way]) != rd_par[hit_way]);
  assign good_hit  = any_hit && !dperr;
  assign cur_uc    = (r_mode == POL_UC);
  assign look_act  = (st == S_LOOK) && !cur_uc;
  assign inval_vec = look_act ? (tperr_vec | (dperr ? (2'b01 << hit_way) : 2'b00)) : 2'b00;
  assign vic       = lock_a | lru_way;
  assign wb_need   = valid_vec[vic] && dirty_vec[vic] && !inval_vec[vic];
  assign wtna_miss = r_we && (r_mode == POL_WTNA);
  assign alloc_dec = look_act && !good_hit && !wtna_miss;
  assign fill_done = (st == S_FILL) && mem_ready;
  assign fill_way  = r_vic;
  assign st_en     = look_act && good_hit && r_we;
  assign parity_err = |inval_vec;
  assign req_ready = (st == S_IDLE);

  dcache_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(r_idx), .tag(r_tag),
    .hit_vec(hit_vec), .tperr_vec(tperr_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .lru_way(lru_way), .sel_way(r_vic), .sel_tag(sel_tag),
    .alloc_en(fill_done), .alloc_way(r_vic), .alloc_tag(r_tag),
    .touch_en((look_act && good_hit) || fill_done), .touch_way(fill_done ? r_vic : hit_way),
    .dirty_en(st_en && r_mode == POL_WB), .dirty_way(hit_way), .inval_vec(inval_vec)
  );

  dcache_data #(.IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
    .clk(clk), .idx(r_idx), .wsel(r_wsel), .rd_word(rd_word), .rd_par(rd_par),
    .ev_way(r_vic), .ev_line(mem_wline),
    .st_en(st_en), .st_way(hit_way), .st_data(r_wdata), .st_be(r_be),
    .fill_en(fill_done), .fill_way(r_vic), .fill_line(mem_rline), .fill_par(mem_rpar)
  );

  always_comb begin
    mem_valid = (st == S_WBK) || (st == S_FILL) || (st == S_MEMW);
    mem_op    = MOP_RDLINE;
    mem_addr  = {r_tag, r_idx, {OFF_W{1'b0}}};
    case (st)
      S_WBK:  begin mem_op = MOP_WRLINE; mem_addr = {sel_tag, r_idx, {OFF_W{1'b0}}}; end
      S_MEMW: begin
        mem_op   = r_we ? MOP_WRWORD : MOP_RDWORD;
        mem_addr = {r_tag, r_idx, r_wsel, 2'b00};
      end
      default: ;
    endcase
  end
  assign mem_wdata = r_wdata;
  assign mem_wbe   = r_be;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; resp_valid <= 1'b0; resp_rdata <= '0;
      r_we <= 1'b0; r_mode <= POL_WB; r_idx <= '0; r_wsel <= '0;
      r_tag <= '0; r_wdata <= '0; r_be <= '0; r_vic <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          r_we <= req_we; r_mode <= pol_e'(req_mode);
          r_idx <= req_vaddr[VA_W-1:OFF_W]; r_wsel <= req_vaddr[OFF_W-1:2];
          r_tag <= req_ptag; r_wdata <= req_wdata; r_be <= req_be;
          st <= S_LOOK;
        end
        S_LOOK: begin
          if (cur_uc || (good_hit && r_we && r_mode != POL_WB) || (!good_hit && wtna_miss)) begin
            st <= S_MEMW;
          end else if (good_hit) begin
            resp_valid <= 1'b1;
            resp_rdata <= r_we ? 32'd0 : rd_word[hit_way];
            st <= S_IDLE;
          end else begin
            r_vic <= vic;
            st <= wb_need ? S_WBK : S_FILL;
          end
        end
        S_WBK:  if (mem_ready) st <= S_FILL;
        S_FILL: if (mem_ready) st <= S_LOOK;
        S_MEMW: if (mem_ready) begin
          resp_valid <= 1'b1;
          resp_rdata <= r_we ? 32'd0 : mem_rline[31:0];
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lock_a,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            parity_err,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [1:0]      mem_op,
  input logic [PA_W-1:0] mem_addr,
  input logic            alloc_dec,
  input logic            fill_done,
  input logic            fill_way,
  input logic            cur_uc
);
  logic dec_lock;
  always_ff @(posedge clk) begin
    if (!rst_n) dec_lock <= 1'b0;
    else if (alloc_dec) dec_lock <= lock_a;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);

  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_op) && $stable(mem_addr)));

  assert_resp_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

  assert_locked_fill_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (!dec_lock || fill_way));

  assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_op == 2'd1) |=> (mem_valid && mem_op == 2'd0));

  assert_uc_word_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && cur_uc) |-> mem_op[1]);

  assert_perr_no_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> !resp_valid);
endmodule

bind dcache_lockable dcache_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/sim_dcache_lockable.sv
`timescale 1ns/1ps
module sim_dcache_lockable;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_a = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [1:0] req_mode = '0;
  logic [11:0] req_vaddr = '0;
  logic [19:0] req_ptag = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, resp_valid, parity_err, mem_valid;
  logic [31:0] resp_rdata, mem_addr, mem_wdata;
  logic [1:0] mem_op;
  logic [255:0] mem_wline;
  logic [3:0] mem_wbe;
  logic mem_ready = 1'b0;
  logic [255:0] mem_rline = '0;
  logic [31:0] mem_rpar = '0;

  always #2.5 clk = ~clk;

  dcache_lockable u0 (.*);

  int total = 0, fails = 0;

  typedef struct {
    logic [1:0] op; logic [31:0] addr; logic [255:0] line;
    logic [31:0] wdata; logic [3:0] be; logic [31:0] inj;
  } xop_t;
  xop_t eq[$];

  // behavioural reference state
  logic [31:0] bmem [int unsigned];
  bit          m_valid [2][128];
  bit          m_dirty [2][128];
  logic [19:0] m_tag   [2][128];
  bit          m_lru   [128];
  logic [31:0] m_dat   [2][128][8];
  logic [3:0]  m_bad   [2][128][8];
  logic [31:0] exp_rdata;
  int          exp_perr;

  function automatic logic [31:0] rdw(input logic [31:0] a);
    int unsigned k = a >> 2;
    if (bmem.exists(k)) return bmem[k];
    return (k * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic void wrw(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] v = rdw(a);
    for (int b = 0; b < 4; b++) if (be[b]) v[8*b +: 8] = d[8*b +: 8];
    bmem[a >> 2] = v;
  endfunction

  function automatic logic [31:0] line_par(input logic [255:0] l);
    logic [31:0] p;
    for (int k = 0; k < 32; k++) p[k] = ^l[8*k +: 8];
    return p;
  endfunction

  function automatic logic [11:0] va(input int idx, input int w);
    return {idx[6:0], w[2:0], 2'b00};
  endfunction

  task automatic chk(input string rq, input string what, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic void push(input logic [1:0] op, input logic [31:0] a, input logic [255:0] l,
                               input logic [31:0] wd, input logic [3:0] be, input logic [31:0] inj);
    xop_t x;
    x.op = op; x.addr = a; x.line = l; x.wdata = wd; x.be = be; x.inj = inj;
    eq.push_back(x);
  endfunction

  // predicts memory operations, load data and parity events for one access
  function automatic void model(input bit we, input logic [1:0] mode, input logic [11:0] v,
                                input logic [19:0] pt, input logic [31:0] wd, input logic [3:0] be,
                                input logic [31:0] inj);
    int idx = v[11:5];
    int w = v[4:2];
    logic [31:0] pa = {pt, v};
    logic [31:0] inj_left = inj;
    exp_rdata = 0; exp_perr = 0;
    if (mode == 2'd3) begin
      push(we ? 2'd3 : 2'd2, {pa[31:2], 2'b00}, '0, wd, be, 0);
      if (we) wrw(pa, wd, be); else exp_rdata = rdw(pa);
      return;
    end
    for (int pass = 0; pass < 4; pass++) begin
      int h = -1;
      for (int way = 0; way < 2; way++) if (m_valid[way][idx] && m_tag[way][idx] == pt) h = way;
      if (h >= 0 && !we && m_bad[h][idx][w] != 0) begin
        exp_perr++; m_valid[h][idx] = 0; h = -1;
      end
      if (h >= 0) begin
        m_lru[idx] = (h == 0);
        if (we) begin
          for (int b = 0; b < 4; b++) if (be[b]) begin
            m_dat[h][idx][w][8*b +: 8] = wd[8*b +: 8];
            m_bad[h][idx][w][b] = 1'b0;
          end
          if (mode == 2'd0) m_dirty[h][idx] = 1;
          else begin push(2'd3, {pa[31:2], 2'b00}, '0, wd, be, 0); wrw(pa, wd, be); end
        end else exp_rdata = m_dat[h][idx][w];
        return;
      end
      if (we && mode == 2'd2) begin
        push(2'd3, {pa[31:2], 2'b00}, '0, wd, be, 0); wrw(pa, wd, be);
        return;
      end
      begin
        int vic = lock_a ? 1 : int'(m_lru[idx]);
        logic [255:0] l;
        if (m_valid[vic][idx] && m_dirty[vic][idx]) begin
          logic [31:0] va_ = {m_tag[vic][idx], idx[6:0], 5'b0};
          for (int k = 0; k < 8; k++) l[32*k +: 32] = m_dat[vic][idx][k];
          push(2'd1, va_, l, 0, 0, 0);
          for (int k = 0; k < 8; k++) wrw(va_ + 32'(4*k), m_dat[vic][idx][k], 4'hF);
        end
        for (int k = 0; k < 8; k++) begin
          l[32*k +: 32] = rdw({pt, idx[6:0], 5'b0} + 32'(4*k));
          m_dat[vic][idx][k] = l[32*k +: 32];
          m_bad[vic][idx][k] = inj_left[4*k +: 4];
        end
        push(2'd0, {pt, idx[6:0], 5'b0}, l, 0, 0, inj_left);
        inj_left = 0;
        m_valid[vic][idx] = 1; m_dirty[vic][idx] = 0; m_tag[vic][idx] = pt;
        m_lru[idx] = (vic == 0);
      end
    end
  endfunction

  task automatic do_req(input bit we, input logic [1:0] mode, input logic [11:0] v, input logic [19:0] pt,
                        input logic [31:0] wd, input logic [3:0] be, input logic [31:0] inj, input string rq);
    int perr = 0, wcnt = 0;
    bit done = 0;
    model(we, mode, v, pt, wd, be, inj);
    while (!req_ready) @(negedge clk);
    req_we = we; req_mode = mode; req_vaddr = v; req_ptag = pt;
    req_wdata = wd; req_be = be; req_valid = 1'b1;
    for (int cyc = 0; cyc < 300 && !done; cyc++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (parity_err) perr++;
      if (mem_ready) begin
        mem_ready = 1'b0; wcnt = 0;
      end else if (mem_valid) begin
        wcnt++;
        if (wcnt == 2) begin
          if (eq.size() == 0) begin
            chk(rq, "unexpected mem op", {mem_op, mem_addr}, '1);
            mem_rline = '0; mem_rpar = '0;
          end else begin
            xop_t x = eq.pop_front();
            chk(rq, "mem_op", mem_op, x.op);
            chk(rq, "mem_addr", mem_addr, x.addr);
            if (x.op == 2'd1) chk(rq, "writeback line", mem_wline, x.line);
            if (x.op == 2'd3) chk(rq, "word write", {mem_wbe, mem_wdata}, {x.be, x.wdata});
            mem_rline = (x.op == 2'd2) ? 256'(rdw(x.addr)) : x.line;
            mem_rpar = line_par(x.line) ^ x.inj;
            if (x.op == 2'd2) mem_rline = 256'(exp_rdata);
          end
          mem_ready = 1'b1;
        end
      end
      if (resp_valid) begin
        done = 1;
        chk(rq, "pending mem ops at response", 256'(eq.size()), 0);
        if (!we) chk(rq, "load data", resp_rdata, exp_rdata);
        chk(rq, "parity_err pulses", 256'(perr), 256'(exp_perr));
      end
    end
    if (!done) chk(rq, "response timeout", 0, 1);
    eq.delete();
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int w = 0; w < 2; w++) for (int s = 0; s < 128; s++) begin
      m_valid[w][s] = 0; m_dirty[w][s] = 0; m_tag[w][s] = 0; m_lru[s] = 0;
      for (int k = 0; k < 8; k++) begin m_dat[w][s][k] = 0; m_bad[w][s][k] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready after reset", req_ready, 1);
    chk("R1", "mem_valid after reset", mem_valid, 0);
    chk("R1", "resp_valid after reset", resp_valid, 0);

    // R1/R2: cold miss, line address and word placement
    do_req(0, 0, va(3, 2), 20'h00011, 0, 0, 0, "R1");
    do_req(0, 0, va(127, 7), 20'hFFFFF, 0, 0, 0, "R2");
    // R3: hit without traffic
    do_req(0, 0, va(3, 2), 20'h00011, 0, 0, 0, "R3");
    do_req(0, 0, va(3, 6), 20'h00011, 0, 0, 0, "R3");
    // R5: LRU choice
    do_req(0, 0, va(3, 0), 20'h00022, 0, 0, 0, "R5");
    do_req(0, 0, va(3, 1), 20'h00011, 0, 0, 0, "R5");
    do_req(0, 0, va(3, 1), 20'h00033, 0, 0, 0, "R5");
    do_req(0, 0, va(3, 4), 20'h00011, 0, 0, 0, "R5");
    // R6: write-back store hit, then read back
    do_req(1, 0, va(3, 1), 20'h00011, 32'hDEADBEEF, 4'b0110, 0, "R6");
    do_req(0, 0, va(3, 1), 20'h00011, 0, 0, 0, "R6");
    // R7: evict the dirty line
    do_req(0, 0, va(3, 0), 20'h00022, 0, 0, 0, "R7");
    do_req(0, 0, va(3, 0), 20'h00044, 0, 0, 0, "R7");
    do_req(0, 0, va(3, 1), 20'h00011, 0, 0, 0, "R7");
    // R6: write-back store miss allocates and merges
    do_req(1, 0, va(9, 5), 20'h00104, 32'h12345678, 4'b1111, 0, "R6");
    do_req(0, 0, va(9, 5), 20'h00104, 0, 0, 0, "R6");
    // R8: write-through with allocate
    do_req(1, 1, va(9, 5), 20'h00104, 32'hA1B2C3D4, 4'b0001, 0, "R8");
    do_req(1, 1, va(10, 3), 20'h00105, 32'hCAFEF00D, 4'b1100, 0, "R8");
    do_req(0, 0, va(10, 3), 20'h00105, 0, 0, 0, "R8");
    do_req(0, 0, va(10, 0), 20'h00205, 0, 0, 0, "R8");
    do_req(0, 0, va(10, 0), 20'h00305, 0, 0, 0, "R8");
    do_req(0, 0, va(10, 3), 20'h00105, 0, 0, 0, "R8");
    // R9: write-through without allocate
    do_req(1, 2, va(11, 2), 20'h00106, 32'h0BADC0DE, 4'b1111, 0, "R9");
    do_req(0, 0, va(11, 2), 20'h00106, 0, 0, 0, "R9");
    do_req(1, 2, va(11, 2), 20'h00106, 32'h55AA55AA, 4'b0011, 0, "R9");
    do_req(0, 0, va(11, 2), 20'h00106, 0, 0, 0, "R9");
    // R10: uncached bypass
    do_req(1, 0, va(12, 4), 20'h00107, 32'h11112222, 4'b1111, 0, "R10");
    do_req(0, 3, va(12, 4), 20'h00107, 0, 0, 0, "R10");
    do_req(1, 3, va(12, 4), 20'h00107, 32'h99998888, 4'b1111, 0, "R10");
    do_req(0, 0, va(12, 4), 20'h00107, 0, 0, 0, "R10");
    // R4: lock way 0
    do_req(0, 0, va(20, 0), 20'h00A00, 0, 0, 0, "R4");
    do_req(0, 0, va(20, 0), 20'h00B00, 0, 0, 0, "R4");
    lock_a = 1'b1;
    do_req(0, 0, va(20, 1), 20'h00C00, 0, 0, 0, "R4");
    do_req(0, 0, va(20, 1), 20'h00D00, 0, 0, 0, "R4");
    do_req(0, 0, va(20, 2), 20'h00A00, 0, 0, 0, "R4");
    do_req(1, 0, va(20, 2), 20'h00D00, 32'h77777777, 4'b1111, 0, "R4");
    do_req(0, 0, va(20, 3), 20'h00E00, 0, 0, 0, "R4");
    do_req(0, 0, va(20, 3), 20'h00A00, 0, 0, 0, "R4");
    lock_a = 1'b0;
    do_req(0, 0, va(20, 4), 20'h00F00, 0, 0, 0, "R5");
    // R11: bad parity in the accessed word forces a refetch
    do_req(0, 0, va(30, 5), 20'h00300, 0, 0, 32'h1 << (5*4 + 2), "R11");
    do_req(0, 0, va(30, 5), 20'h00300, 0, 0, 0, "R11");
    do_req(0, 0, va(31, 5), 20'h00301, 0, 0, 32'h1 << (1*4 + 3), "R11");
    do_req(0, 0, va(31, 1), 20'h00301, 0, 0, 0, "R11");
    // R12: store regenerates parity only for written bytes
    do_req(0, 0, va(40, 6), 20'h00400, 0, 0, (32'h1 << (3*4)) | (32'h1 << (4*4)), "R12");
    do_req(1, 0, va(40, 3), 20'h00400, 32'h3C3C3C3C, 4'b1111, 0, "R12");
    do_req(0, 0, va(40, 3), 20'h00400, 0, 0, 0, "R12");
    do_req(1, 0, va(40, 4), 20'h00400, 32'h00AB0000, 4'b0100, 0, "R12");
    do_req(0, 0, va(40, 4), 20'h00400, 0, 0, 0, "R12");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule